// File: doc/BRIEF.md
# Lane Shuffle and Reduction Unit

This unit moves data between the 32 lanes of a lockstep SIMT datapath. One operation at a time is offered on a valid/ready input. Each offer carries one signed 32-bit word per lane, a mask of active lanes, a 2-bit operation code and a 5-bit selector. Two operations are permutations: a shift-down by an offset and a butterfly exchange by an XOR pattern. Two are reductions across lanes, a sum and a signed maximum, and both give the result to every active lane.

All four operations use the same lane crossbar. A permutation makes one pass through the crossbar from the input register and delivers its result one cycle after acceptance. A reduction makes five butterfly passes. Pass s exchanges each lane with the lane whose index differs in bit s and then combines the pair, so after the last pass every lane holds the full result. Passes one to four each end in a register, which puts the reduction result at the output five cycles after acceptance.

The output is a registered vector of lane words with a one-cycle valid pulse. Lanes outside the mask of an operation keep their earlier output words. Only one operation is in flight at a time, so results come out in the order they were accepted.

Top module: `lane_xchg_unit`

## Requirements
- R1: After reset, out_valid_o is 0, every lane word of out_data_o is 0 and in_ready_o is 1.
- R2: An operation is accepted on a clock edge where in_valid_i and in_ready_o are both 1. in_ready_o stays 0 from that edge until the edge that delivers the result, and out_valid_o is 1 for exactly one cycle per accepted operation. Lane l occupies bits [32l+31:32l] of data_i and out_data_o. op_i encodes 0 = shift-down, 1 = XOR exchange, 2 = sum, 3 = signed max.
- R3: Shift-down with offset k = sel_i: active lane i receives the input word of lane i+k when i+k <= 31, and its own input word otherwise. An offset of 0 returns the inputs unchanged. A source lane is read whether or not its mask bit is set.
- R4: XOR exchange with pattern m = sel_i: active lane i receives the input word of lane i XOR m. A source lane is read whether or not its mask bit is set.
- R5: A permutation result appears on out_data_o with out_valid_o high after the first clock edge following the acceptance edge.
- R6: Sum: every active lane receives the two's complement total, modulo 2^32, of the words of the active lanes. Inactive lanes contribute 0. Lanes holding 1 through 32 with all lanes active give 528 in every lane.
- R7: Max: every active lane receives the largest signed word among the active lanes. Inactive lanes contribute 0x80000000.
- R8: A reduction result appears with out_valid_o high after the fifth clock edge following the acceptance edge.
- R9: Output lanes whose mask bit is 0 keep their previous words, and out_data_o does not change in any cycle where no result is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Unit can accept an operation |
| op_i | input | 2 | Operation code |
| sel_i | input | 5 | Shift offset or XOR pattern |
| mask_i | input | 32 | Active-lane mask |
| data_i | input | 1024 | Input word of each lane |
| out_valid_o | output | 1 | One-cycle result strobe |
| out_data_o | output | 1024 | Output word of each lane |

## Verification
A permutation result is due on the first rising edge after the acceptance edge. A reduction result is due on the fifth. After each acceptance edge the bench samples the outputs 1 ns past every rising edge and counts the edges until out_valid_o appears. It checks that count against 1 or 5, and checks that in_ready_o fell just after the acceptance edge. The lane words are compared on the strobe cycle: active lanes against a model of the four operations, inactive lanes against the words the model kept from earlier results. The checker measures the same latencies with a cycle counter that starts at acceptance.

// File: rtl/lane_xchg_pkg.sv
package lane_xchg_pkg;
  typedef enum logic [1:0] {
    OP_SHFL_DN  = 2'd0,
    OP_BFLY_XOR = 2'd1,
    OP_RED_SUM  = 2'd2,
    OP_RED_MAX  = 2'd3
  } xop_e;
endpackage

// File: rtl/lane_xbar.sv
// Per-lane source select: dst lane l takes src lane sel[l].
module lane_xbar #(
  parameter int NL = 32,
  parameter int W  = 32,
  localparam int IW = $clog2(NL)
) (
  input  logic [NL*W-1:0]  src_i,
  input  logic [NL*IW-1:0] sel_i,
  output logic [NL*W-1:0]  dst_o
);
  logic [W-1:0] src_a [NL];

  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign src_a[l]          = src_i[l*W +: W];
    assign dst_o[l*W +: W]   = src_a[sel_i[l*IW +: IW]];
  end
endmodule

// File: rtl/lane_combine.sv
// Pairwise combine for one butterfly pass: wrapping sum or signed max.
module lane_combine #(
  parameter int NL = 32,
  parameter int W  = 32
) (
  input  logic            is_max_i,
  input  logic [NL*W-1:0] a_i,
  input  logic [NL*W-1:0] b_i,
  output logic [NL*W-1:0] y_o
);
  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [W-1:0] a, b;
    assign a = a_i[l*W +: W];
    assign b = b_i[l*W +: W];
    assign y_o[l*W +: W] = is_max_i ? (($signed(a) > $signed(b)) ? a : b)
                                    : a + b;
  end
endmodule

// File: rtl/lane_xchg_unit.sv
module lane_xchg_unit
  import lane_xchg_pkg::*;
#(
  parameter int NL = 32,
  parameter int W  = 32,
  localparam int IW   = $clog2(NL),
  localparam int NSTG = IW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [1:0]     op_i,
  input  logic [IW-1:0]  sel_i,
  input  logic [NL-1:0]  mask_i,
  input  logic [NL*W-1:0] data_i,
  output logic           out_valid_o,
  output logic [NL*W-1:0] out_data_o
);
  localparam logic [W-1:0] MAX_IDENT = {1'b1, {(W-1){1'b0}}};

  // input register
  logic            q_vld;
  xop_e            q_op;
  logic [IW-1:0]   q_sel;
  logic [NL-1:0]   q_mask;
  logic [NL*W-1:0] q_data;

  // reduction pass registers, passes 1..NSTG-1
  logic [NSTG-1:1] r_vld;
  logic [NSTG-1:1] r_max;
  logic [NL-1:0]   r_mask [NSTG];
  logic [NL*W-1:0] r_data [NSTG];

  logic accept, busy;

  assign busy       = q_vld | (|r_vld);
  assign in_ready_o = ~busy;
  assign accept     = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_vld  <= 1'b0;
      q_op   <= OP_SHFL_DN;
      q_sel  <= '0;
      q_mask <= '0;
      q_data <= '0;
    end else begin
      q_vld <= accept;
      if (accept) begin
        q_op   <= xop_e'(op_i);
        q_sel  <= sel_i;
        q_mask <= mask_i;
        q_data <= data_i;
      end
    end
  end

  // permutation path
  logic            sh_fire;
  logic [NL*IW-1:0] sh_idx;
  logic [NL*W-1:0]  sh_res;

  assign sh_fire = q_vld & ((q_op == OP_SHFL_DN) | (q_op == OP_BFLY_XOR));

  always_comb begin
    for (int l = 0; l < NL; l++) begin
      logic [IW:0] tgt;
      tgt = {1'b0, IW'(l)} + {1'b0, q_sel};
      if (q_op == OP_BFLY_XOR)
        sh_idx[l*IW +: IW] = IW'(l) ^ q_sel;
      else
        sh_idx[l*IW +: IW] = tgt[IW] ? IW'(l) : tgt[IW-1:0];  // past top lane: keep own
    end
  end

  lane_xbar #(.NL(NL), .W(W)) u_sh_xbar (
    .src_i (q_data),
    .sel_i (sh_idx),
    .dst_o (sh_res)
  );

  // reduction path: pass s pairs lane l with lane l ^ (1 << s)
  logic            st_vld  [NSTG];
  logic            st_max  [NSTG];
  logic [NL-1:0]   st_mask [NSTG];
  logic [NL*W-1:0] st_in   [NSTG];
  logic [NL*W-1:0] st_peer [NSTG];
  logic [NL*W-1:0] st_out  [NSTG];
  logic [NL*W-1:0] seed;

  always_comb begin
    for (int l = 0; l < NL; l++)
      seed[l*W +: W] = q_mask[l] ? q_data[l*W +: W]
                     : ((q_op == OP_RED_MAX) ? MAX_IDENT : '0);
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    logic [NL*IW-1:0] pidx;

    if (s == 0) begin : g_head
      assign st_vld[s]  = q_vld & ((q_op == OP_RED_SUM) | (q_op == OP_RED_MAX));
      assign st_max[s]  = (q_op == OP_RED_MAX);
      assign st_mask[s] = q_mask;
      assign st_in[s]   = seed;
    end else begin : g_body
      assign st_vld[s]  = r_vld[s];
      assign st_max[s]  = r_max[s];
      assign st_mask[s] = r_mask[s];
      assign st_in[s]   = r_data[s];
    end

    for (genvar l = 0; l < NL; l++) begin : g_pidx
      assign pidx[l*IW +: IW] = IW'(l ^ (1 << s));
    end

    lane_xbar #(.NL(NL), .W(W)) u_xbar (
      .src_i (st_in[s]),
      .sel_i (pidx),
      .dst_o (st_peer[s])
    );

    lane_combine #(.NL(NL), .W(W)) u_comb (
      .is_max_i (st_max[s]),
      .a_i      (st_in[s]),
      .b_i      (st_peer[s]),
      .y_o      (st_out[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_vld <= '0;
      r_max <= '0;
      for (int s = 0; s < NSTG; s++) begin
        r_mask[s] <= '0;
        r_data[s] <= '0;
      end
    end else begin
      r_mask[0] <= '0;
      r_data[0] <= '0;
      for (int s = 1; s < NSTG; s++) begin
        r_vld[s]  <= st_vld[s-1];
        r_max[s]  <= st_max[s-1];
        r_mask[s] <= st_mask[s-1];
        r_data[s] <= st_out[s-1];
      end
    end
  end

  // output register: only active lanes of the delivering operation update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= sh_fire | st_vld[NSTG-1];
      for (int l = 0; l < NL; l++) begin
        if (sh_fire && q_mask[l])
          out_data_o[l*W +: W] <= sh_res[l*W +: W];
        else if (st_vld[NSTG-1] && st_mask[NSTG-1][l])
          out_data_o[l*W +: W] <= st_out[NSTG-1][l*W +: W];
      end
    end
  end
endmodule

// File: rtl/lane_xchg_chk.sv
module lane_xchg_chk #(
  parameter int NL = 32,
  parameter int W  = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic [1:0]      op_i,
  input logic [NL-1:0]   mask_i,
  input logic            out_valid_o,
  input logic [NL*W-1:0] out_data_o
);
  localparam int RED_LAT = $clog2(NL);

  logic          acc;
  logic          pend, hred;
  logic [3:0]    age;
  logic [NL-1:0] hmask;

  assign acc = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend  <= 1'b0;
      hred  <= 1'b0;
      age   <= '0;
      hmask <= '0;
    end else begin
      if (pend && age != 4'hf) age <= age + 4'd1;
      if (out_valid_o) pend <= 1'b0;
      if (acc) begin
        pend  <= 1'b1;
        hred  <= op_i[1];
        age   <= '0;
        hmask <= mask_i;
      end
    end
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !in_ready_o);

  // R2
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  // R5
  perm_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && pend && !hred) |-> (age == 4'd1));

  // R8
  red_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && pend && hred) |-> (age == 4'(RED_LAT)));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_data_o));

  for (genvar l = 0; l < NL; l++) begin : g_lane
    // R9
    masked_lane_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !hmask[l]) |-> $stable(out_data_o[l*W +: W]));
  end
endmodule

bind lane_xchg_unit lane_xchg_chk #(.NL(NL), .W(W)) u_lane_xchg_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .op_i        (op_i),
  .mask_i      (mask_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o)
);

// File: tb/lane_xchg_unit_bench.sv
module lane_xchg_unit_bench;
  localparam int  NL       = 32;
  localparam int  W        = 32;
  localparam time CLK_PER  = 10ns;
  localparam int  WDOG_CYC = 100000;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid_i = 1'b0;
  logic            in_ready_o;
  logic [1:0]      op_i = '0;
  logic [4:0]      sel_i = '0;
  logic [NL-1:0]   mask_i = '0;
  logic [NL*W-1:0] data_i = '0;
  logic            out_valid_o;
  logic [NL*W-1:0] out_data_o;

  int checks = 0;
  int errors = 0;
  logic [NL*W-1:0] exp_out = '0;

  always #(CLK_PER/2) clk_i = ~clk_i;

  lane_xchg_unit u_lane_xchg_unit (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .op_i, .sel_i,
    .mask_i, .data_i, .out_valid_o, .out_data_o
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NL*W-1:0] model(input logic [1:0] op, input logic [4:0] sel,
                                             input logic [NL-1:0] msk,
                                             input logic [NL*W-1:0] din);
    logic [NL*W-1:0] r;
    logic [W-1:0] acc;
    acc = (op == 2'd3) ? 32'h8000_0000 : 32'h0;
    for (int l = 0; l < NL; l++)
      if (msk[l]) begin
        if (op == 2'd2) acc = acc + din[l*W +: W];
        else if ($signed(din[l*W +: W]) > $signed(acc)) acc = din[l*W +: W];
      end
    for (int l = 0; l < NL; l++) begin
      case (op)
        2'd0:    r[l*W +: W] = (l + sel > NL-1) ? din[l*W +: W] : din[(l+sel)*W +: W];
        2'd1:    r[l*W +: W] = din[(l ^ sel)*W +: W];
        default: r[l*W +: W] = acc;
      endcase
    end
    return r;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [4:0] sel,
                        input logic [NL-1:0] msk, input logic [NL*W-1:0] din);
    logic [NL*W-1:0] full, expv;
    int lat;
    string tag;
    full = model(op, sel, msk, din);
    for (int l = 0; l < NL; l++)
      expv[l*W +: W] = msk[l] ? full[l*W +: W] : exp_out[l*W +: W];
    case (op)
      2'd0: tag = "R3";
      2'd1: tag = "R4";
      2'd2: tag = "R6";
      default: tag = "R7";
    endcase
    @(negedge clk_i);
    while (!in_ready_o) @(negedge clk_i);
    in_valid_i = 1'b1; op_i = op; sel_i = sel; mask_i = msk; data_i = din;
    @(posedge clk_i); #1;
    in_valid_i = 1'b0;
    chk(in_ready_o == 1'b0, "R2", 32'(in_ready_o), 32'h0, "ready after accept");
    lat = 0;
    while (!out_valid_o && lat < 20) begin
      @(posedge clk_i); #1;
      lat++;
    end
    if (op < 2'd2)
      chk(lat == 1, "R5", 32'(lat), 32'd1, "permutation latency");
    else
      chk(lat == 5, "R8", 32'(lat), 32'd5, "reduction latency");
    for (int l = 0; l < NL; l++) begin
      if (out_data_o[l*W +: W] !== expv[l*W +: W]) begin
        chk(1'b0, msk[l] ? tag : "R9", out_data_o[l*W +: W], expv[l*W +: W],
            $sformatf("lane %0d", l));
        break;
      end
      if (l == NL-1) chk(1'b1, tag, '0, '0, "lanes");
    end
    exp_out = expv;
    @(posedge clk_i); #1;
    chk(out_valid_o == 1'b0, "R2", 32'(out_valid_o), 32'h0, "strobe width");
    chk(out_data_o === exp_out, "R9", out_data_o[31:0], exp_out[31:0], "idle hold");
  endtask

  function automatic logic [NL*W-1:0] rnd_vec();
    logic [NL*W-1:0] v;
    for (int l = 0; l < NL; l++) v[l*W +: W] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (WDOG_CYC) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", WDOG_CYC);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NL*W-1:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk_i);
    #1;
    chk(out_valid_o == 1'b0, "R1", 32'(out_valid_o), 32'h0, "valid in reset");
    chk(out_data_o == '0, "R1", out_data_o[31:0], 32'h0, "data in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(in_ready_o == 1'b1, "R1", 32'(in_ready_o), 32'h1, "ready after reset");

    // R6: lanes 1..32 sum to 528
    for (int l = 0; l < NL; l++) v[l*W +: W] = 32'(l + 1);
    run_op(2'd2, 5'd0, '1, v);
    // R3: offset 0, offset 2, offset 31
    run_op(2'd0, 5'd0, '1, v);
    run_op(2'd0, 5'd2, '1, v);
    run_op(2'd0, 5'd31, '1, rnd_vec());
    // R4: pair swap and quad swap
    run_op(2'd1, 5'd1, '1, v);
    run_op(2'd1, 5'd4, '1, v);
    // R6: wrap modulo 2^32
    for (int l = 0; l < NL; l++) v[l*W +: W] = 32'h7fff_ffff;
    run_op(2'd2, 5'd0, '1, v);
    // R7: all negative, largest lane masked off
    for (int l = 0; l < NL; l++) v[l*W +: W] = -32'(l + 10);
    run_op(2'd3, 5'd0, 32'hffff_fffe, v);
    // R9: empty mask changes nothing
    run_op(2'd2, 5'd0, '0, rnd_vec());
    run_op(2'd1, 5'd7, 32'h0000_ffff, rnd_vec());

    for (int i = 0; i < 60; i++) begin
      logic [NL-1:0] m;
      m = ($urandom % 4 == 0) ? '1 : NL'($urandom);
      run_op(2'($urandom), 5'($urandom), m, rnd_vec());
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule